// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Controller

This controller steers the two ALU operands of a five-stage pipeline toward the freshest copy of their source registers, so that dependent instructions seldom need to wait. Every cycle, and for each operand of the instruction in execute on its own, it picks one of four sources. The first is the execute/memory ALU result. The second is the memory/writeback result, which may be ALU output or loaded data. The third is a one-entry latch that holds the value written back in the previous cycle. The last is the register file. Each source match is a separate hazard with a fixed priority: the youngest producer wins.

Forwarding cannot cover one case: a load in execute whose destination is read by the instruction in decode. For this case the controller holds the program counter and the decode register and puts a no-operation into execute. This costs exactly one cycle. After that cycle the loaded value is forwarded from memory/writeback. The controller keeps the register tag and the valid bit of the write-back latch itself. The data values and the multiplexers they feed belong to the datapath.

Top module: `byp_forward_ctrl`

## Requirements
- R1: After reset the latch tag is invalid, no stall is raised, and with idle inputs both selects read 0 (register file).
- R2: Select encoding is 0 register file, 1 execute/memory result, 2 memory/writeback result, 3 write-back latch. An operand that is read and matches a writing execute/memory destination selects 1.
- R3: With no execute/memory match, a read operand that matches a writing memory/writeback destination selects 2.
- R4: The latch tag takes the memory/writeback destination and write flag on every clock. A read operand that matches only a valid latch tag selects 3 in the following cycle.
- R5: When several stages write the operand's register, the youngest wins. The order is execute/memory, then memory/writeback, then latch, then register file.
- R6: Operands A and B are resolved independently and may select different sources in the same cycle. Operand B also carries store data, so it forwards in the same way.
- R7: A stage whose write flag is low is never selected, and an operand flagged as not read always selects 0.
- R8: If execute holds a load that writes register r, and the decode instruction reads r on either operand, then hold_pc, hold_ifid and bubble_idex are all high in that cycle.
- R9: The stall never lasts two consecutive cycles, even if the load-use condition is still present.
- R10: A load whose destination the decode instruction does not read, or a non-load producer, raises no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_rs_a | input | REG_W | Decode-stage source register A |
| id_rs_b | input | REG_W | Decode-stage source register B |
| id_use_a | input | 1 | Decode instruction reads A |
| id_use_b | input | 1 | Decode instruction reads B |
| ex_rs_a | input | REG_W | Execute-stage source register A |
| ex_rs_b | input | REG_W | Execute-stage source register B |
| ex_use_a | input | 1 | Execute instruction reads A |
| ex_use_b | input | 1 | Execute instruction reads B (including store data) |
| ex_rd | input | REG_W | Execute-stage destination |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| exm_rd | input | REG_W | Execute/memory destination |
| exm_wen | input | 1 | Execute/memory writes a register |
| mwb_rd | input | REG_W | Memory/writeback destination |
| mwb_wen | input | 1 | Memory/writeback writes a register |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B source select |
| hold_pc | output | 1 | Hold program counter |
| hold_ifid | output | 1 | Hold fetch/decode register |
| bubble_idex | output | 1 | Load a no-operation into decode/execute |

## Verification
A load-use stall and operand forwarding can happen in the same cycle. The stall is caused by the decode instruction, and the forwarding serves the load that sits in execute. To provoke both at once, the bench places a load in execute whose own source operands match the execute/memory destination and a valid latch tag, and gives decode an instruction that reads the load's destination. It then requires all three stall outputs to be high while both selects show the sources the priority rule predicts. In the next cycle the bench keeps the same condition and checks that the stall has dropped.

// File: rtl/byp_pkg.sv
package byp_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_EXM = 2'd1,
    SRC_MWB = 2'd2,
    SRC_WBL = 2'd3
  } byp_src_e;

  localparam int N_OPER = 2;
endpackage

// File: rtl/byp_wb_tag.sv
module byp_wb_tag #(
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] mwb_rd,
  input  logic             mwb_wen,
  output logic [REG_W-1:0] wbl_rd,
  output logic             wbl_vld
);
  // Tag of the value the register file absorbed on the last edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbl_rd  <= '0;
      wbl_vld <= 1'b0;
    end else begin
      wbl_rd  <= mwb_rd;
      wbl_vld <= mwb_wen;
    end
  end

  a_r4_latch_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    wbl_vld |-> ($past(mwb_wen) && wbl_rd == $past(mwb_rd)));
endmodule

// File: rtl/byp_operand_sel.sv
module byp_operand_sel #(
  parameter int REG_W = 3
) (
  input  logic [REG_W-1:0]  src_reg,
  input  logic              src_used,
  input  logic [REG_W-1:0]  exm_rd,
  input  logic              exm_wen,
  input  logic [REG_W-1:0]  mwb_rd,
  input  logic              mwb_wen,
  input  logic [REG_W-1:0]  wbl_rd,
  input  logic              wbl_vld,
  output byp_pkg::byp_src_e sel
);
  import byp_pkg::*;

  logic hit_exm, hit_mwb, hit_wbl;

  // Each hazard kept separate; youngest producer first
  always_comb begin
    hit_exm = src_used && exm_wen && (exm_rd == src_reg);
    hit_mwb = src_used && mwb_wen && (mwb_rd == src_reg);
    hit_wbl = src_used && wbl_vld && (wbl_rd == src_reg);
    if (hit_exm)      sel = SRC_EXM;
    else if (hit_mwb) sel = SRC_MWB;
    else if (hit_wbl) sel = SRC_WBL;
    else              sel = SRC_RF;
  end
endmodule

// File: rtl/byp_load_use.sv
module byp_load_use #(
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ex_is_load,
  input  logic             ex_wen,
  input  logic [REG_W-1:0] ex_rd,
  input  logic [REG_W-1:0] id_rs_a,
  input  logic [REG_W-1:0] id_rs_b,
  input  logic             id_use_a,
  input  logic             id_use_b,
  output logic             stall
);
  logic dep_a, dep_b, raw_hazard, stall_q;

  always_comb begin
    dep_a      = id_use_a && (id_rs_a == ex_rd);
    dep_b      = id_use_b && (id_rs_b == ex_rd);
    raw_hazard = ex_is_load && ex_wen && (dep_a || dep_b);
    // a single bubble is enough: after it the load sits in memory/writeback
    stall      = raw_hazard && !stall_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall;
  end

  a_r9_one_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  a_r10_load_only: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_is_load && ex_wen));
endmodule

// File: rtl/byp_forward_ctrl.sv
module byp_forward_ctrl #(
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs_a,
  input  logic [REG_W-1:0] id_rs_b,
  input  logic             id_use_a,
  input  logic             id_use_b,
  input  logic [REG_W-1:0] ex_rs_a,
  input  logic [REG_W-1:0] ex_rs_b,
  input  logic             ex_use_a,
  input  logic             ex_use_b,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] exm_rd,
  input  logic             exm_wen,
  input  logic [REG_W-1:0] mwb_rd,
  input  logic             mwb_wen,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             hold_pc,
  output logic             hold_ifid,
  output logic             bubble_idex
);
  import byp_pkg::*;

  logic [REG_W-1:0] wbl_rd;
  logic             wbl_vld;
  logic             stall;

  logic [N_OPER-1:0][REG_W-1:0] op_reg;
  logic [N_OPER-1:0]            op_used;
  byp_src_e                     op_sel [N_OPER];

  assign op_reg  = {ex_rs_b, ex_rs_a};
  assign op_used = {ex_use_b, ex_use_a};

  byp_wb_tag #(.REG_W(REG_W)) u_tag (
    .clk(clk), .rst_n(rst_n), .mwb_rd(mwb_rd), .mwb_wen(mwb_wen),
    .wbl_rd(wbl_rd), .wbl_vld(wbl_vld)
  );

  for (genvar g = 0; g < N_OPER; g++) begin : g_oper
    byp_operand_sel #(.REG_W(REG_W)) u_sel (
      .src_reg(op_reg[g]), .src_used(op_used[g]),
      .exm_rd(exm_rd), .exm_wen(exm_wen),
      .mwb_rd(mwb_rd), .mwb_wen(mwb_wen),
      .wbl_rd(wbl_rd), .wbl_vld(wbl_vld),
      .sel(op_sel[g])
    );
  end

  byp_load_use #(.REG_W(REG_W)) u_lu (
    .clk(clk), .rst_n(rst_n), .ex_is_load(ex_is_load), .ex_wen(ex_wen),
    .ex_rd(ex_rd), .id_rs_a(id_rs_a), .id_rs_b(id_rs_b),
    .id_use_a(id_use_a), .id_use_b(id_use_b), .stall(stall)
  );

  assign sel_a       = op_sel[0];
  assign sel_b       = op_sel[1];
  assign hold_pc     = stall;
  assign hold_ifid   = stall;
  assign bubble_idex = stall;

  a_r7_exm_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == SRC_EXM || sel_b == SRC_EXM) |-> exm_wen);
  a_r7_mwb_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == SRC_MWB || sel_b == SRC_MWB) |-> mwb_wen);
  a_r4_wbl_prior_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == SRC_WBL) |-> ($past(mwb_wen) && $past(mwb_rd) == ex_rs_a));
  a_r7_unused_rf: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_use_a |-> sel_a == SRC_RF) and (!ex_use_b |-> sel_b == SRC_RF));
endmodule

// File: tb/byp_forward_ctrl_bench.sv
module byp_forward_ctrl_bench;
  localparam int RW = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [RW-1:0] id_rs_a, id_rs_b, ex_rs_a, ex_rs_b, ex_rd, exm_rd, mwb_rd;
  logic id_use_a, id_use_b, ex_use_a, ex_use_b, ex_wen, ex_is_load, exm_wen, mwb_wen;
  logic [1:0] sel_a, sel_b;
  logic hold_pc, hold_ifid, bubble_idex;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  byp_forward_ctrl #(.REG_W(RW)) u_byp_forward_ctrl (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_stall(string req, bit exp);
    chk(req, {hold_pc, hold_ifid, bubble_idex}, exp ? 7 : 0);
  endtask

  task automatic idle();
    id_rs_a = 0; id_rs_b = 0; id_use_a = 0; id_use_b = 0;
    ex_rs_a = 0; ex_rs_b = 0; ex_use_a = 0; ex_use_b = 0;
    ex_rd = 0; ex_wen = 0; ex_is_load = 0;
    exm_rd = 0; exm_wen = 0; mwb_rd = 0; mwb_wen = 0;
  endtask

  // one idle cycle clears the latch tag and the stall memory
  task automatic flush();
    @(negedge clk); idle(); @(negedge clk);
  endtask

  task automatic t_reset();
    idle(); ex_use_a = 1; ex_use_b = 1;
    #1; chk("R1 sel_a", sel_a, 0); chk("R1 sel_b", sel_b, 0);
    chk_stall("R1 stall", 0);
  endtask

  task automatic t_exm();
    flush();
    ex_rs_a = 3; ex_use_a = 1; exm_rd = 3; exm_wen = 1;
    #1; chk("R2 exm", sel_a, 1); chk("R2 other rf", sel_b, 0);
  endtask

  task automatic t_mwb();
    flush();
    ex_rs_b = 5; ex_use_b = 1; mwb_rd = 5; mwb_wen = 1; exm_rd = 4; exm_wen = 1;
    #1; chk("R3 mwb", sel_b, 2);
  endtask

  task automatic t_wbl();
    flush();
    mwb_rd = 6; mwb_wen = 1;
    @(negedge clk);
    mwb_wen = 0; mwb_rd = 1; ex_rs_a = 6; ex_use_a = 1;
    #1; chk("R4 latch", sel_a, 3);
    @(negedge clk);
    #1; chk("R4 latch expires", sel_a, 0);
  endtask

  task automatic t_priority();
    flush();
    mwb_rd = 2; mwb_wen = 1;
    @(negedge clk);
    ex_rs_a = 2; ex_use_a = 1; mwb_rd = 2; mwb_wen = 1; exm_rd = 2; exm_wen = 1;
    #1; chk("R5 exm over all", sel_a, 1);
    exm_wen = 0;
    #1; chk("R5 mwb over latch", sel_a, 2);
    mwb_rd = 7;
    #1; chk("R5 latch over rf", sel_a, 3);
  endtask

  task automatic t_independent();
    flush();
    ex_rs_a = 1; ex_use_a = 1; ex_rs_b = 4; ex_use_b = 1;
    exm_rd = 4; exm_wen = 1; mwb_rd = 1; mwb_wen = 1;
    #1; chk("R6 a mwb", sel_a, 2); chk("R6 b store data exm", sel_b, 1);
  endtask

  task automatic t_nowrite();
    flush();
    ex_rs_a = 3; ex_use_a = 1; ex_rs_b = 3; ex_use_b = 0;
    exm_rd = 3; exm_wen = 0; mwb_rd = 3; mwb_wen = 0;
    #1; chk("R7 no writer", sel_a, 0); chk("R7 unused operand", sel_b, 0);
  endtask

  task automatic t_load_use();
    flush();
    ex_is_load = 1; ex_wen = 1; ex_rd = 3; id_rs_b = 3; id_use_b = 1;
    #1; chk_stall("R8 load-use on B", 1);
    @(negedge clk);
    ex_is_load = 0; ex_wen = 0; exm_rd = 3; exm_wen = 1;
    #1; chk_stall("R9 after bubble", 0);
    @(negedge clk);
    exm_wen = 0; mwb_rd = 3; mwb_wen = 1; ex_rs_b = 3; ex_use_b = 1;
    #1; chk("R8 loaded data from mwb", sel_b, 2);
  endtask

  task automatic t_single_bubble();
    flush();
    ex_is_load = 1; ex_wen = 1; ex_rd = 5; id_rs_a = 5; id_use_a = 1;
    #1; chk_stall("R8 load-use on A", 1);
    @(negedge clk);
    #1; chk_stall("R9 no second bubble", 0);
  endtask

  task automatic t_no_user();
    flush();
    ex_is_load = 1; ex_wen = 1; ex_rd = 5; id_rs_a = 4; id_use_a = 1; id_rs_b = 5;
    #1; chk_stall("R10 unread dest", 0);
    ex_is_load = 0; id_rs_a = 5;
    #1; chk_stall("R10 alu producer", 0);
  endtask

  task automatic t_concurrent();
    flush();
    mwb_rd = 6; mwb_wen = 1;
    @(negedge clk);
    mwb_wen = 0;
    ex_is_load = 1; ex_wen = 1; ex_rd = 2; ex_rs_a = 1; ex_use_a = 1;
    ex_rs_b = 6; ex_use_b = 1; exm_rd = 1; exm_wen = 1;
    id_rs_a = 2; id_use_a = 1;
    #1; chk_stall("R8 stall with forwarding", 1);
    chk("R5 load base from exm", sel_a, 1); chk("R4 load index from latch", sel_b, 3);
    @(negedge clk);
    #1; chk_stall("R9 concurrent one bubble", 0);
  endtask

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_exm();
    t_mwb();
    t_wbl();
    t_priority();
    t_independent();
    t_nowrite();
    t_load_use();
    t_single_bubble();
    t_no_user();
    t_concurrent();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule